// File: doc/BRIEF.md
# Battery Charge Sequencer

This block is the digital sequencer of a linear lithium-ion charger. Comparator flags describe the battery and the thermistor: above the dead-cell level, at float voltage, below the recharge level, current under one tenth of the programmed value, thermistor in range, and thermistor input grounded. From these flags the block picks a charge mode: off, reduced (C/10), full rate, or constant voltage. It runs a pausable event timer that measures time spent in the timed phases. It also drives the status flags that a separate pin encoder turns into a steady or blinking indication.

Time comes from a slow pulse input, `tick_i`. A prescaler divides it into timer units, so a bench can use short timeouts and a chip can use minutes. Each phase change restarts the event timer. The timer advances only in the reduced-rate phase (to detect a dead cell) and in the constant-voltage phase (to end the cycle). All inputs are plain level or pulse signals. None of them carries a data stream, so there is no handshake at the block's edge.

Top module: `chg_seq`

## Requirements
- R1: While `en_i` is low, or after reset, the sequencer sits in its idle state. There `mode_o` is 0 (off) and `chg_low_o`, `ntc_fault_o`, `bad_cell_o` and `done_o` are all 0. Leaving idle always starts the event timer from zero.
- R2: In idle with `en_i` high, one clock later the mode follows the battery. It becomes 1 (C/10) when `bat_ok_i` is 0, 3 (constant voltage) when `bat_ok_i` and `bat_float_i` are both 1, and 2 (full rate) otherwise. `mode_o` encodes off=0, C/10=1, full=2, constant voltage=3.
- R3: In C/10 mode, once the event timer has counted `BAD_UNITS` units, the next clock stops charging (mode 0) and raises `bad_cell_o`. This state is kept until `restart_i` or `en_i` low.
- R4: In C/10 mode, `bat_ok_i`=1 moves to full rate. In full rate, `bat_ok_i`=0 returns to C/10 and `bat_float_i`=1 moves to constant voltage. Each change takes effect one clock later.
- R5: In constant-voltage mode, once the event timer has counted `TOTAL_UNITS` units, the next clock ends the cycle. Then `mode_o` is 0 and `done_o` is 1.
- R6: While charging, `chg_low_o` is 1. In constant-voltage mode, `ibat_low_i`=1 clears `chg_low_o` from the next clock until the phase ends, while charging continues in mode 3.
- R7: A thermistor out of range (`ntc_ok_i`=0 while charging) at once gives mode 0, `ntc_fault_o`=1 and `chg_low_o`=0, and freezes the phase and the event timer. When `ntc_ok_i` returns, the same phase resumes with its elapsed time kept.
- R8: With `ntc_gnd_i`=1 the thermistor flag is ignored: `ntc_fault_o` stays 0 and charging continues.
- R9: After the cycle ends, charging is inhibited while `bat_rechg_i` is 0. When it is 1, the sequencer goes to idle on the next clock and starts a new cycle per R2 one clock after that.
- R10: A one-cycle `restart_i` pulse returns the sequencer to idle on the next clock and clears `bad_cell_o` and `done_o`.
- R11: One timer unit is `PRESCALE` pulses of `tick_i`. The timer counts units only in C/10 and constant-voltage mode while not paused, and it restarts from zero on every phase change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| en_i | input | 1 | charger enable |
| restart_i | input | 1 | host restart pulse |
| tick_i | input | 1 | slow time pulse, one clock wide |
| bat_ok_i | input | 1 | battery above dead-cell level |
| bat_float_i | input | 1 | battery at float voltage |
| bat_rechg_i | input | 1 | battery below recharge level |
| ibat_low_i | input | 1 | charge current below C/10 |
| ntc_ok_i | input | 1 | thermistor temperature in range |
| ntc_gnd_i | input | 1 | thermistor input grounded (checks off) |
| mode_o | output | 2 | charge mode: 0 off, 1 C/10, 2 full, 3 constant voltage |
| chg_low_o | output | 1 | charging indication (pin pulled low) |
| ntc_fault_o | output | 1 | thermistor fault flag |
| bad_cell_o | output | 1 | bad-battery fault flag |
| done_o | output | 1 | cycle ended, charging inhibited |

## Verification
The thermistor pause and its release act on the outputs in the same cycle, because the outputs decode the registered phase together with the live thermistor flags. Every phase change, the C/10 release and the fault flags appear one clock after the input that causes them. Timeouts appear one clock after the unit that brings the count to its limit. A recharge needs two clocks: one to reach idle, one to select the mode. The bench drives inputs shortly after the falling edge. At the next falling edge it compares every output with a reference model that steps once per rising edge, so each result is checked in exactly the cycle in which it is due.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TRKL = 3'd1,
    ST_FULL = 3'd2,
    ST_CV   = 3'd3,
    ST_BAD  = 3'd4,
    ST_DONE = 3'd5
  } chg_state_e;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_C10  = 2'd1,
    MODE_FULL = 2'd2,
    MODE_CV   = 2'd3
  } chg_mode_e;

  function automatic logic is_charging(chg_state_e s);
    return (s == ST_TRKL) || (s == ST_FULL) || (s == ST_CV);
  endfunction

  function automatic logic is_timed(chg_state_e s);
    return (s == ST_TRKL) || (s == ST_CV);
  endfunction

endpackage

// File: rtl/chg_prescaler.sv
module chg_prescaler #(
  parameter int unsigned DIV = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic unit_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign unit_o = tick_i;
    end else begin : g_div
      logic [PW-1:0] pre_q;
      logic          wrap;
      assign wrap   = (pre_q == PW'(DIV - 1));
      assign unit_o = tick_i & wrap;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else if (tick_i) begin
          pre_q <= wrap ? '0 : pre_q + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/chg_event_timer.sv
module chg_event_timer #(
  parameter int unsigned MAXV = 240
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       run_i,
  input  logic                       unit_i,
  output logic [$clog2(MAXV+1)-1:0]  cnt_o
);
  localparam int unsigned CW = $clog2(MAXV + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (run_i && unit_i && (cnt_q != CW'(MAXV))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/chg_fsm.sv
module chg_fsm
  import chg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       restart_i,
  input  logic       bat_ok_i,
  input  logic       bat_float_i,
  input  logic       bat_rechg_i,
  input  logic       ibat_low_i,
  input  logic       ntc_ok_i,
  input  logic       ntc_gnd_i,
  input  logic       bad_hit_i,
  input  logic       total_hit_i,
  output chg_state_e state_o,
  output logic       pause_o,
  output logic       change_o,
  output logic       c10_seen_o
);
  chg_state_e state_q, state_d, pick;
  logic       c10_q, c10_d, pause;

  assign pause = is_charging(state_q) & ~ntc_gnd_i & ~ntc_ok_i;

  always_comb begin
    if (!bat_ok_i)        pick = ST_TRKL;
    else if (bat_float_i) pick = ST_CV;
    else                  pick = ST_FULL;
  end

  always_comb begin
    state_d = state_q;
    if (!en_i || restart_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = pick;
        ST_TRKL: begin
          if (!pause) begin
            if (bat_ok_i)       state_d = ST_FULL;
            else if (bad_hit_i) state_d = ST_BAD;
          end
        end
        ST_FULL: begin
          if (!pause) begin
            if (!bat_ok_i)        state_d = ST_TRKL;
            else if (bat_float_i) state_d = ST_CV;
          end
        end
        ST_CV: begin
          if (!pause && total_hit_i) state_d = ST_DONE;
        end
        ST_BAD:  state_d = ST_BAD;
        ST_DONE: begin
          if (bat_rechg_i) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (state_d != state_q)                  c10_d = 1'b0;
    else if (state_q == ST_CV && ibat_low_i) c10_d = 1'b1;
    else                                     c10_d = c10_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      c10_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      c10_q   <= c10_d;
    end
  end

  assign state_o    = state_q;
  assign pause_o    = pause;
  assign change_o   = (state_d != state_q);
  assign c10_seen_o = c10_q;
endmodule

// File: rtl/chg_status.sv
module chg_status
  import chg_pkg::*;
(
  input  chg_state_e state_i,
  input  logic       pause_i,
  input  logic       c10_seen_i,
  output logic [1:0] mode_o,
  output logic       chg_low_o,
  output logic       ntc_fault_o,
  output logic       bad_cell_o,
  output logic       done_o
);
  chg_mode_e mode;

  always_comb begin
    mode = MODE_OFF;
    if (!pause_i) begin
      unique case (state_i)
        ST_TRKL: mode = MODE_C10;
        ST_FULL: mode = MODE_FULL;
        ST_CV:   mode = MODE_CV;
        default: mode = MODE_OFF;
      endcase
    end
  end

  assign mode_o      = mode;
  assign chg_low_o   = is_charging(state_i) & ~pause_i & ~c10_seen_i;
  assign ntc_fault_o = pause_i;
  assign bad_cell_o  = (state_i == ST_BAD);
  assign done_o      = (state_i == ST_DONE);
endmodule

// File: rtl/chg_seq.sv
module chg_seq
  import chg_pkg::*;
#(
  parameter int unsigned PRESCALE    = 60,
  parameter int unsigned BAD_UNITS   = 30,
  parameter int unsigned TOTAL_UNITS = 240
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       restart_i,
  input  logic       tick_i,
  input  logic       bat_ok_i,
  input  logic       bat_float_i,
  input  logic       bat_rechg_i,
  input  logic       ibat_low_i,
  input  logic       ntc_ok_i,
  input  logic       ntc_gnd_i,
  output logic [1:0] mode_o,
  output logic       chg_low_o,
  output logic       ntc_fault_o,
  output logic       bad_cell_o,
  output logic       done_o
);
  localparam int unsigned MAXV = (BAD_UNITS > TOTAL_UNITS) ? BAD_UNITS : TOTAL_UNITS;
  localparam int unsigned CW   = $clog2(MAXV + 1);

  chg_state_e    state;
  logic          pause, change, c10_seen, unit;
  logic [CW-1:0] cnt;

  chg_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .unit_o(unit)
  );

  chg_event_timer #(.MAXV(MAXV)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr_i(change),
    .run_i(is_timed(state) & ~pause), .unit_i(unit), .cnt_o(cnt)
  );

  chg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .restart_i(restart_i),
    .bat_ok_i(bat_ok_i), .bat_float_i(bat_float_i), .bat_rechg_i(bat_rechg_i),
    .ibat_low_i(ibat_low_i), .ntc_ok_i(ntc_ok_i), .ntc_gnd_i(ntc_gnd_i),
    .bad_hit_i(cnt >= CW'(BAD_UNITS)), .total_hit_i(cnt >= CW'(TOTAL_UNITS)),
    .state_o(state), .pause_o(pause), .change_o(change), .c10_seen_o(c10_seen)
  );

  chg_status u_sts (
    .state_i(state), .pause_i(pause), .c10_seen_i(c10_seen),
    .mode_o(mode_o), .chg_low_o(chg_low_o), .ntc_fault_o(ntc_fault_o),
    .bad_cell_o(bad_cell_o), .done_o(done_o)
  );
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       restart_i,
  input logic       ibat_low_i,
  input logic       ntc_gnd_i,
  input logic [1:0] mode_o,
  input logic       chg_low_o,
  input logic       ntc_fault_o,
  input logic       bad_cell_o,
  input logic       done_o
);
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (mode_o == 2'd0) && !bad_cell_o && !done_o && !chg_low_o); // R1
  AST_BAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cell_o && en_i && !restart_i |=> bad_cell_o); // R3
  AST_BAD_NO_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cell_o |-> mode_o == 2'd0); // R3
  AST_DONE_NO_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (mode_o == 2'd0) && !chg_low_o); // R5
  AST_C10_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && !restart_i && (mode_o == 2'd3) && ibat_low_i |=> !chg_low_o); // R6
  AST_NTC_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ntc_fault_o |-> (mode_o == 2'd0) && !chg_low_o); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chg_low_o, ntc_fault_o, bad_cell_o, done_o})); // R7
  AST_NTC_GND_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ntc_gnd_i |-> !ntc_fault_o); // R8
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !bad_cell_o && !done_o && (mode_o == 2'd0)); // R10
endmodule

bind chg_seq chg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .restart_i(restart_i),
  .ibat_low_i(ibat_low_i), .ntc_gnd_i(ntc_gnd_i), .mode_o(mode_o),
  .chg_low_o(chg_low_o), .ntc_fault_o(ntc_fault_o),
  .bad_cell_o(bad_cell_o), .done_o(done_o)
);

// File: tb/chg_seq_tb.sv
module chg_seq_tb;
  localparam int P   = 2;
  localparam int BAD = 5;
  localparam int TOT = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en_i = 0, restart_i = 0, tick_i = 0, bat_ok_i = 0, bat_float_i = 0;
  logic bat_rechg_i = 0, ibat_low_i = 0, ntc_ok_i = 1, ntc_gnd_i = 0;
  logic [1:0] mode_o;
  logic chg_low_o, ntc_fault_o, bad_cell_o, done_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit live = 0;

  always #10 clk = ~clk;

  chg_seq #(.PRESCALE(P), .BAD_UNITS(BAD), .TOTAL_UNITS(TOT)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .restart_i(restart_i), .tick_i(tick_i),
    .bat_ok_i(bat_ok_i), .bat_float_i(bat_float_i), .bat_rechg_i(bat_rechg_i),
    .ibat_low_i(ibat_low_i), .ntc_ok_i(ntc_ok_i), .ntc_gnd_i(ntc_gnd_i),
    .mode_o(mode_o), .chg_low_o(chg_low_o), .ntc_fault_o(ntc_fault_o),
    .bad_cell_o(bad_cell_o), .done_o(done_o)
  );

  // Reference model: 0 idle, 1 C/10, 2 full, 3 CV, 4 bad, 5 done
  int m_st = 0, m_pre = 0, m_cnt = 0;
  bit m_c10 = 0;

  function automatic bit chg(int s); return s >= 1 && s <= 3; endfunction
  function automatic bit m_pause(); return chg(m_st) && !ntc_gnd_i && !ntc_ok_i; endfunction
  function automatic int exp_mode(); return (m_pause() || !chg(m_st)) ? 0 : m_st; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pre = 0; m_cnt = 0; m_c10 = 0;
    end else begin
      bit unit, pz, run;
      int nx, pick;
      unit = tick_i && (m_pre == P - 1);
      if (tick_i) m_pre = (m_pre == P - 1) ? 0 : m_pre + 1;
      pz   = m_pause();
      run  = (m_st == 1 || m_st == 3) && !pz;
      pick = !bat_ok_i ? 1 : (bat_float_i ? 3 : 2);
      nx   = m_st;
      if (!en_i || restart_i) nx = 0;
      else case (m_st)
        0: nx = pick;
        1: if (!pz) begin if (bat_ok_i) nx = 2; else if (m_cnt >= BAD) nx = 4; end
        2: if (!pz) begin if (!bat_ok_i) nx = 1; else if (bat_float_i) nx = 3; end
        3: if (!pz && m_cnt >= TOT) nx = 5;
        5: if (bat_rechg_i) nx = 0;
        default: ;
      endcase
      if (nx != m_st) begin m_cnt = 0; m_c10 = 0; end
      else begin
        if (run && unit && m_cnt < TOT) m_cnt++;
        if (m_st == 3 && ibat_low_i) m_c10 = 1;
      end
      m_st = nx;
    end
  end

  task automatic cmp(string tag, int act, int expv, string what);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, expv, $time);
    end
  endtask

  function automatic string tag_of();
    if (ntc_gnd_i && chg(m_st)) return "R8";
    if (m_pause()) return "R7";
    case (m_st)
      0: return "R1"; 1: return "R11"; 2: return "R4";
      3: return "R6"; 4: return "R3"; default: return "R5";
    endcase
  endfunction

  always @(negedge clk) if (live) begin
    string t;
    t = tag_of();
    cmp(t, mode_o, exp_mode(), "mode");
    cmp(t, chg_low_o, chg(m_st) && !m_pause() && !m_c10, "chg_low");
    cmp(t, ntc_fault_o, m_pause(), "ntc_fault");
    cmp(t, bad_cell_o, m_st == 4, "bad_cell");
    cmp(t, done_o, m_st == 5, "done");
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    process::self().srandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; live = 1; #2;
    step(1);
    cmp("R1", mode_o, 0, "mode after reset");
    // R2: dead battery selects C/10
    tick_i = 1; en_i = 1; step(1);
    cmp("R2", mode_o, 1, "C/10 select");
    // R3: bad cell after BAD units
    step(2 * BAD * P + 4);
    cmp("R3", bad_cell_o, 1, "bad cell");
    cmp("R3", mode_o, 0, "bad cell mode");
    // R10: restart clears
    restart_i = 1; step(1); restart_i = 0;
    cmp("R10", bad_cell_o, 0, "restart clears bad");
    // R4: full then CV
    bat_ok_i = 1; step(2);
    cmp("R4", mode_o, 2, "full rate");
    bat_float_i = 1; step(1);
    cmp("R4", mode_o, 3, "constant voltage");
    // R6: C/10 releases pin
    ibat_low_i = 1; step(1); ibat_low_i = 0;
    cmp("R6", chg_low_o, 0, "pin released");
    cmp("R6", mode_o, 3, "still charging");
    // R5: total timeout
    step(TOT * P + 4);
    cmp("R5", done_o, 1, "done");
    // R9: recharge
    bat_float_i = 0; bat_rechg_i = 1; step(2); bat_rechg_i = 0;
    cmp("R9", mode_o, 2, "new cycle");
    // R7: NTC pause and resume
    ntc_ok_i = 0; #1;
    cmp("R7", ntc_fault_o, 1, "ntc fault");
    step(10); ntc_ok_i = 1; #1;
    cmp("R7", mode_o, 2, "resume");
    // R8: grounded thermistor
    ntc_gnd_i = 1; ntc_ok_i = 0; step(3);
    cmp("R8", ntc_fault_o, 0, "grounded");
    ntc_gnd_i = 0; ntc_ok_i = 1;
    // R1: disable
    en_i = 0; step(1);
    cmp("R1", mode_o, 0, "disabled");
    // random phase (R11 timing covered by model)
    for (int i = 0; i < 6000; i++) begin
      tick_i      = $urandom_range(0, 1);
      en_i        = ($urandom_range(0, 99) < 97);
      restart_i   = ($urandom_range(0, 199) == 0);
      if ($urandom_range(0, 9) == 0) bat_ok_i    = $urandom_range(0, 1);
      if ($urandom_range(0, 9) == 0) bat_float_i = $urandom_range(0, 1);
      if ($urandom_range(0, 19) == 0) bat_rechg_i = $urandom_range(0, 1);
      ibat_low_i  = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 29) == 0) ntc_ok_i  = $urandom_range(0, 3) != 0;
      if ($urandom_range(0, 59) == 0) ntc_gnd_i = $urandom_range(0, 3) == 0;
      step(1);
    end
    live = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule